// File: doc/BRIEF.md
# Multi-State Trigger Sequencer

This block decides when a logic-analyzer capture fires. On every clock it may be handed one qualified sample word from the probes. It runs that word through a small program of states. Each state holds an ordered list of clauses, and each clause can test three things:

- the sample against a masked match word,
- one event counter against a terminal value,
- one elapsed-time timer against a limit.

In each cycle only the first clause that is true in the current state acts. Its action can move to another state, increment or clear the counter, start or stop the timer, or fire the trigger. Together these let a program express sequences, loops and time windows, for example "word A five times, then word B within N cycles, otherwise start over". The program has no stall cycles: every valid sample is judged in the cycle it arrives.

The program is loaded through a single-cycle register-write port. An arm pulse starts a run. When the trigger fires, the block raises a one-cycle pulse and a sticky flag, and it then stays idle until the next arm pulse.

Top module: `trig_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, `cur_state` is 0 and `armed`, `triggered` and `trig_pulse` are all 0.
- R2: The pattern test of a clause passes when `(sample & mask) == (value & mask)`. Mask bits at 0 are don't-care. Control bit 1 enables the test; when it is 0 the pattern always passes.
- R3: Clauses in a state are checked from index 0 upward. Only the lowest-index true clause acts in a cycle, even when later clauses are also true.
- R4: A clause whose control bit 0 is 0 never acts. A cycle with `sample_vld` low runs no clause. In both cases the state, counter and trigger are unchanged.
- R5: Control bits [12:11] set the counter action: 1 increments the counter (wrapping), 2 clears it, and 0 or 3 leave it unchanged. Control bits [3:2] set the counter test: 1 requires counter == terminal, 2 requires counter != terminal, and 0 or 3 mean no test. The terminal value is written at global field 0.
- R6: Control bits [14:13] set the timer action: 1 restarts the timer at 0 and runs it, and 2 stops and zeroes it. A running timer advances by one on every armed clock until it reaches the limit, which is written at global field 1. The timer counts as expired when it is running and its value is at least the limit. Control bits [5:4] set the timer test: 1 requires expired, 2 requires not expired, and 0 or 3 mean no test.
- R7: When the acting clause has control bit 15 set, the next cycle shows `trig_pulse` = 1 for exactly one cycle. In that same cycle `triggered` becomes 1 and stays 1, `armed` drops and `cur_state` returns to 0.
- R8: While `armed` is 0, `cur_state` stays 0 and no clause acts.
- R9: A cycle with `arm` high sets `armed`, clears `triggered`, returns to state 0, and clears the counter and the timer. It overrides any clause that is true in the same cycle.
- R10: An acting clause with control bit 10 set and bit 15 clear moves `cur_state` to control bits [9:6] on the next cycle. Jumps may go back to earlier states, which forms loops.
- R11: Configuration write address: {global bit [10], state [9:6], clause [5:2], field [1:0]}. With the global bit clear, field 0 is the clause's mask, field 1 its value and field 2 its control word. With the global bit set, field 0 is the counter terminal and field 1 the timer limit.
- R12: The program "A seen 5 times, then B within the window, otherwise restart" triggers when B arrives within the window. When the window expires first, the sequence restarts and the five A words must be seen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 11 | Configuration address |
| cfg_wdata | input | 16 | Configuration write data |
| arm | input | 1 | Start a new trigger sequence |
| sample_vld | input | 1 | Sample word is qualified this cycle |
| sample | input | 16 | Probe sample word |
| armed | output | 1 | Sequencer is running |
| triggered | output | 1 | Sticky trigger flag |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| cur_state | output | 4 | Current program state |

## Verification
Every result is registered once, so a sample, arm pulse or configuration write presented in one cycle is reflected at the ports one clock later. A configuration write affects clause evaluation from the cycle after that. The timer reaches expiry exactly `limit` armed clocks after the clause that starts it, and a clause testing for expiry acts on the first valid sample after that point. The bench drives inputs on the falling edge and updates its behavioural model on the rising edge. It compares all four outputs on every falling edge, and its directed checks sample at the falling edge that follows each stimulus, with the timer window counted out edge by edge.

// File: rtl/trig_seq.sv
module trig_seq #(
  parameter int DW = 16,
  parameter int NS = 16,
  parameter int NC = 16,
  parameter int CW = 16,
  parameter int TW = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cfg_we,
  input  logic [$clog2(NS)+$clog2(NC)+2:0]   cfg_addr,
  input  logic [DW-1:0]                      cfg_wdata,
  input  logic                               arm,
  input  logic                               sample_vld,
  input  logic [DW-1:0]                      sample,
  output logic                               armed,
  output logic                               triggered,
  output logic                               trig_pulse,
  output logic [$clog2(NS)-1:0]              cur_state
);
  localparam int SW   = $clog2(NS);
  localparam int KW   = $clog2(NC);
  localparam int CTLW = 12 + SW;

  logic [DW-1:0]   mask_q [NS][NC];
  logic [DW-1:0]   val_q  [NS][NC];
  logic [CTLW-1:0] ctl_q  [NS][NC];

  logic [SW-1:0] state_q;
  logic          armed_q, hold_q, pulse_q;
  logic [CW-1:0] cnt_q, term_q;
  logic [TW-1:0] tmr_q, lim_q;
  logic          run_q;

  wire          glb   = cfg_addr[SW+KW+2];
  wire [SW-1:0] w_st  = cfg_addr[KW+2 +: SW];
  wire [KW-1:0] w_cl  = cfg_addr[2 +: KW];
  wire [1:0]    w_fld = cfg_addr[1:0];

  wire cnt_hit = (cnt_q == term_q);
  wire tmr_exp = run_q && (tmr_q >= lim_q);

  logic          hit;
  logic [KW-1:0] sel;
  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int k = 0; k < NC; k++) begin
      logic [CTLW-1:0] c;
      logic pat_ok, cnt_ok, tmr_ok;
      c = ctl_q[state_q][k];
      pat_ok = !c[1] || (((sample ^ val_q[state_q][k]) & mask_q[state_q][k]) == '0);
      cnt_ok = (c[3:2] == 2'd1) ? cnt_hit : (c[3:2] == 2'd2) ? !cnt_hit : 1'b1;
      tmr_ok = (c[5:4] == 2'd1) ? tmr_exp : (c[5:4] == 2'd2) ? !tmr_exp : 1'b1;
      if (!hit && c[0] && pat_ok && cnt_ok && tmr_ok) begin
        hit = 1'b1;
        sel = k[KW-1:0];
      end
    end
  end

  wire [CTLW-1:0] act  = ctl_q[state_q][sel];
  wire            fire = armed_q && sample_vld && hit;
  wire [SW-1:0]   nxt  = act[6 +: SW];
  wire            jmp  = act[6+SW];
  wire [1:0]      cop  = act[7+SW +: 2];
  wire [1:0]      top  = act[9+SW +: 2];
  wire            trg  = act[11+SW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NS; s++)
        for (int k = 0; k < NC; k++) begin
          mask_q[s][k] <= '0;
          val_q[s][k]  <= '0;
          ctl_q[s][k]  <= '0;
        end
      term_q <= '0;
      lim_q  <= '0;
    end else if (cfg_we) begin
      if (glb) begin
        if (w_fld == 2'd0) term_q <= cfg_wdata[CW-1:0];
        if (w_fld == 2'd1) lim_q  <= cfg_wdata[TW-1:0];
      end else if (int'(w_st) < NS && int'(w_cl) < NC) begin
        if (w_fld == 2'd0) mask_q[w_st][w_cl] <= cfg_wdata;
        if (w_fld == 2'd1) val_q[w_st][w_cl]  <= cfg_wdata;
        if (w_fld == 2'd2) ctl_q[w_st][w_cl]  <= cfg_wdata[CTLW-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= '0;
      armed_q <= 1'b0;
      hold_q  <= 1'b0;
      pulse_q <= 1'b0;
      cnt_q   <= '0;
      tmr_q   <= '0;
      run_q   <= 1'b0;
    end else if (arm) begin
      state_q <= '0;
      armed_q <= 1'b1;
      hold_q  <= 1'b0;
      pulse_q <= 1'b0;
      cnt_q   <= '0;
      tmr_q   <= '0;
      run_q   <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (armed_q && run_q && tmr_q < lim_q) tmr_q <= tmr_q + 1'b1;
      if (fire) begin
        if (cop == 2'd1) cnt_q <= cnt_q + 1'b1;
        else if (cop == 2'd2) cnt_q <= '0;
        if (top == 2'd1) begin
          tmr_q <= '0;
          run_q <= 1'b1;
        end else if (top == 2'd2) begin
          tmr_q <= '0;
          run_q <= 1'b0;
        end
        if (trg) begin
          pulse_q <= 1'b1;
          hold_q  <= 1'b1;
          armed_q <= 1'b0;
          state_q <= '0;
        end else if (jmp && int'(nxt) < NS) begin
          state_q <= nxt;
        end
      end
    end
  end

  assign armed      = armed_q;
  assign triggered  = hold_q;
  assign trig_pulse = pulse_q;
  assign cur_state  = state_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) trig_pulse |=> !trig_pulse); // R7
  AST_PULSE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n) trig_pulse |-> (triggered && !armed)); // R7
  AST_IDLE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !armed |-> (cur_state == '0)); // R8
  AST_ARM_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n) arm |=> (armed && !triggered && cur_state == '0)); // R9
  AST_NO_VLD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (armed && !sample_vld && !arm) |=> ($stable(cur_state) && !trig_pulse)); // R4
  AST_PULSE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n) $rose(trig_pulse) |-> $past(armed)); // R7
endmodule

// File: tb/tb_trig_seq.sv
module tb_trig_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [10:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        arm = 1'b0;
  logic        sample_vld = 1'b0;
  logic [15:0] sample = '0;
  logic        armed, triggered, trig_pulse;
  logic [3:0]  cur_state;

  int total = 0;
  int bad = 0;
  bit done = 0;

  trig_seq dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .arm(arm), .sample_vld(sample_vld), .sample(sample),
    .armed(armed), .triggered(triggered), .trig_pulse(trig_pulse), .cur_state(cur_state)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int  mm [16][16];
  int  mv [16][16];
  int  mc [16][16];
  int  m_st = 0, m_cnt = 0, m_term = 0, m_tmr = 0, m_lim = 0;
  bit  m_run = 0, m_arm = 0, m_hold = 0, m_pulse = 0;

  function automatic int fld(int c, int lo, int n);
    return (c >> lo) & ((1 << n) - 1);
  endfunction

  always @(posedge clk) begin
    int found;
    int c;
    bit exp_t, hit_c, ok;
    if (!rst_n) begin
      foreach (mm[s, k]) begin mm[s][k] = 0; mv[s][k] = 0; mc[s][k] = 0; end
      m_st = 0; m_cnt = 0; m_term = 0; m_tmr = 0; m_lim = 0;
      m_run = 0; m_arm = 0; m_hold = 0; m_pulse = 0;
    end else begin
      exp_t = m_run && (m_tmr >= m_lim);
      hit_c = (m_cnt == m_term);
      found = -1;
      for (int k = 0; k < 16; k++) begin
        c = mc[m_st][k];
        ok = fld(c, 0, 1) == 1;
        if (fld(c, 1, 1) == 1 && ((sample & mm[m_st][k]) != (mv[m_st][k] & mm[m_st][k]))) ok = 0;
        if (fld(c, 2, 2) == 1 && !hit_c) ok = 0;
        if (fld(c, 2, 2) == 2 && hit_c) ok = 0;
        if (fld(c, 4, 2) == 1 && !exp_t) ok = 0;
        if (fld(c, 4, 2) == 2 && exp_t) ok = 0;
        if (ok) begin found = k; break; end
      end
      c = (found >= 0) ? mc[m_st][found] : 0;
      if (cfg_we) begin
        if (cfg_addr[10]) begin
          if (cfg_addr[1:0] == 0) m_term = cfg_wdata;
          if (cfg_addr[1:0] == 1) m_lim = cfg_wdata;
        end else begin
          if (cfg_addr[1:0] == 0) mm[cfg_addr[9:6]][cfg_addr[5:2]] = cfg_wdata;
          if (cfg_addr[1:0] == 1) mv[cfg_addr[9:6]][cfg_addr[5:2]] = cfg_wdata;
          if (cfg_addr[1:0] == 2) mc[cfg_addr[9:6]][cfg_addr[5:2]] = cfg_wdata;
        end
      end
      m_pulse = 0;
      if (arm) begin
        m_arm = 1; m_hold = 0; m_st = 0; m_cnt = 0; m_tmr = 0; m_run = 0;
      end else begin
        if (m_arm && m_run && m_tmr < m_lim) m_tmr++;
        if (m_arm && sample_vld && found >= 0) begin
          if (fld(c, 11, 2) == 1) m_cnt = (m_cnt + 1) & 16'hFFFF;
          else if (fld(c, 11, 2) == 2) m_cnt = 0;
          if (fld(c, 13, 2) == 1) begin m_tmr = 0; m_run = 1; end
          else if (fld(c, 13, 2) == 2) begin m_tmr = 0; m_run = 0; end
          if (fld(c, 15, 1) == 1) begin
            m_pulse = 1; m_hold = 1; m_arm = 0; m_st = 0;
          end else if (fld(c, 10, 1) == 1) m_st = fld(c, 6, 4);
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R10 cur_state vs model", cur_state, m_st);
      chk("R7 trig_pulse vs model", trig_pulse, m_pulse);
      chk("R7 triggered vs model", triggered, m_hold);
      chk("R9 armed vs model", armed, m_arm);
    end
  end

  function automatic logic [10:0] ca(int st, int cl, int f);
    return {1'b0, st[3:0], cl[3:0], f[1:0]};
  endfunction

  // control: [0]en [1]pat [3:2]cnt test [5:4]tmr test [9:6]next [10]jmp [12:11]cnt op [14:13]tmr op [15]trig
  function automatic logic [15:0] mk(int pat, int ct, int tt, int nx, int jp, int co, int to, int tg);
    return 16'(1 | (pat << 1) | (ct << 2) | (tt << 4) | (nx << 6) | (jp << 10) | (co << 11) | (to << 13) | (tg << 15));
  endfunction

  task automatic wr(logic [10:0] a, logic [15:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic clause(int st, int cl, int msk, int val, logic [15:0] ctl);
    wr(ca(st, cl, 0), 16'(msk));
    wr(ca(st, cl, 1), 16'(val));
    wr(ca(st, cl, 2), ctl);
  endtask

  task automatic smp(bit v, logic [15:0] d);
    sample_vld = v; sample = d;
    @(negedge clk);
    sample_vld = 0;
  endtask

  task automatic do_arm();
    arm = 1;
    @(negedge clk);
    arm = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 state in reset", cur_state, 0);
    chk("R1 armed in reset", armed, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 triggered after reset", triggered, 0);
    chk("R1 pulse after reset", trig_pulse, 0);

    clause(0, 0, 16'hFFFF, 16'h00A5, mk(1, 0, 0, 3, 1, 0, 0, 0));
    clause(3, 0, 16'h00F0, 16'h0030, mk(1, 0, 0, 5, 1, 0, 0, 0));
    clause(5, 0, 16'h0001, 16'h0001, mk(1, 0, 0, 6, 1, 0, 0, 0));
    clause(5, 1, 16'h0000, 16'h0000, mk(0, 0, 0, 7, 1, 0, 0, 0));
    clause(6, 0, 16'h0000, 16'h0000, mk(0, 0, 0, 9, 1, 0, 0, 0) & 16'hFFFE);
    clause(6, 1, 16'h0000, 16'h0000, mk(0, 0, 0, 8, 1, 0, 0, 0));
    clause(8, 0, 16'h0000, 16'h0000, mk(0, 0, 0, 0, 0, 0, 0, 1));

    smp(1, 16'h00A5);
    chk("R8 no move while unarmed", cur_state, 0);
    do_arm();
    chk("R9 arm sets armed", armed, 1);
    smp(1, 16'h00A4);
    chk("R2 mismatch holds state 0", cur_state, 0);
    smp(1, 16'h00A5);
    chk("R10 R11 exact match jumps to 3", cur_state, 3);
    smp(1, 16'h1244);
    chk("R2 masked mismatch holds", cur_state, 3);
    smp(0, 16'h1234);
    chk("R4 invalid sample ignored", cur_state, 3);
    smp(1, 16'h1234);
    chk("R2 masked match jumps to 5", cur_state, 5);
    smp(1, 16'h0003);
    chk("R3 first true clause wins", cur_state, 6);
    smp(1, 16'h0000);
    chk("R4 disabled clause skipped", cur_state, 8);
    smp(0, 16'h0000);
    chk("R4 no trigger without valid", trig_pulse, 0);
    smp(1, 16'h0000);
    chk("R7 pulse raised", trig_pulse, 1);
    chk("R7 state back to 0", cur_state, 0);
    chk("R7 disarmed", armed, 0);
    smp(1, 16'h00A5);
    chk("R7 pulse lasts one cycle", trig_pulse, 0);
    chk("R7 triggered sticky", triggered, 1);
    chk("R8 unarmed ignores clauses", cur_state, 0);

    // A x5 then B within window
    wr(11'h400, 16'd4);
    wr(11'h401, 16'd6);
    clause(0, 0, 16'hFFFF, 16'h1111, mk(1, 1, 0, 1, 1, 2, 1, 0));
    clause(0, 1, 16'hFFFF, 16'h1111, mk(1, 0, 0, 0, 0, 1, 0, 0));
    clause(1, 0, 16'hFFFF, 16'h2222, mk(1, 0, 2, 0, 0, 0, 0, 1));
    clause(1, 1, 16'h0000, 16'h0000, mk(0, 0, 1, 0, 1, 2, 2, 0));
    do_arm();
    chk("R9 arm clears triggered", triggered, 0);
    for (int i = 0; i < 4; i++) begin
      smp(1, 16'h1111);
      smp(1, 16'h0000);
    end
    chk("R5 four A stay in 0", cur_state, 0);
    smp(1, 16'h1111);
    chk("R5 fifth A reaches 1", cur_state, 1);
    for (int i = 0; i < 6; i++) smp(1, 16'h0000);
    chk("R6 window still open", cur_state, 1);
    smp(1, 16'h0000);
    chk("R6 R12 expiry restarts", cur_state, 0);
    for (int i = 0; i < 4; i++) smp(1, 16'h1111);
    chk("R5 R12 count cleared on restart", cur_state, 0);
    smp(1, 16'h1111);
    chk("R12 fifth A again", cur_state, 1);
    smp(1, 16'h0000);
    smp(1, 16'h0000);
    smp(1, 16'h2222);
    chk("R12 B in window triggers", trig_pulse, 1);
    chk("R12 triggered set", triggered, 1);
    smp(1, 16'h0000);
    chk("R7 pulse cleared", trig_pulse, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule